// File: doc/BRIEF.md
# Cache Miss Reservation Queue

This block parks requests that missed in a pipelined, non-blocking cache bank until the line they need has been filled, and then hands them back to the front of the pipeline. A missed request arrives from the last pipeline stage together with everything needed to replay it. Each entry records the line address, word select, write word, thread id, request tag, read/write flag, byte enables, a snoop flag and a snoop-invalidate flag. Each entry also carries an initial ready bit that the last stage computes.

Entries marked not-ready wait until a fill for their line is accepted at the pipeline input. At that point every waiting entry for that line becomes ready. The oldest ready entry is offered on the dequeue side. When the pipeline takes it with a schedule strobe, it is held in flight until the last stage either commits it, which frees the slot, or sends it back, which keeps its slot and its age. A live hazard flag tells the pipeline input whether any parked entry targets the line it is presenting, so that newer requests to that line can be forced to queue behind it. Full and almost-full flags let upstream logic stop admitting new work while the misses already in the pipeline can still find space.

Top module: `miss_park_queue`

## Requirements
- R1: After reset, `empty` is 1 and `full`, `almost_full`, `deq_valid` and `hazard` are 0.
- R2: An entry written by a new enqueue is presented on the dequeue outputs with every stored field unchanged: address, word select, write word, thread id, tag, write flag, byte enables, snoop flag and snoop-invalidate flag.
- R3: A new entry whose `enq_ready_init` is 1 can be offered from the cycle after its enqueue. An entry enqueued with 0 is never offered before a matching fill.
- R4: When `fill_valid` is 1, every parked, not-in-flight entry whose address equals `probe_addr` becomes ready on the next cycle, and entries for other lines stay waiting. An entry that is enqueued in the same cycle with `enq_addr` equal to `probe_addr` also becomes ready.
- R5: `hazard` is combinational and is 1 exactly when some occupied slot holds a line address equal to `probe_addr`.
- R6: Among ready entries, the one enqueued earliest is the one offered on the dequeue outputs.
- R7: `sched` while `deq_valid` is 1 puts the offered entry in flight. No entry is offered again until that entry is committed or sent back.
- R8: `commit` frees the in-flight slot, so occupancy drops by one on the next cycle.
- R9: An enqueue with `enq_back` set returns the in-flight entry to its own slot. Occupancy does not change, the new ready value is `enq_ready_init` (or a same-cycle matching fill), and the entry keeps its age relative to the others.
- R10: `full` is 1 when all DEPTH slots are occupied. A new enqueue while `full` is 1 is ignored and leaves no trace at the outputs.
- R11: `almost_full` is 1 when the number of free slots is below GAP, the count of pipeline stages between schedule and enqueue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enq_valid | input | 1 | Enqueue strobe from the last stage |
| enq_back | input | 1 | 1: the enqueue returns the in-flight entry; 0: it is a new entry |
| enq_ready_init | input | 1 | Initial ready bit for the entry |
| enq_addr | input | AW | Line address |
| enq_wsel | input | WSW | Word select within the line |
| enq_wdata | input | WW | Write word |
| enq_tid | input | TIDW | Thread id |
| enq_tag | input | TAGW | Request tag |
| enq_wr | input | 1 | 1 for a write |
| enq_ben | input | WW/8 | Byte enables |
| enq_snp | input | 1 | Snoop request flag |
| enq_snp_inv | input | 1 | Snoop invalidate flag |
| fill_valid | input | 1 | A fill for line `probe_addr` is accepted this cycle |
| probe_addr | input | AW | Line address presented at the pipeline input |
| hazard | output | 1 | An occupied slot matches `probe_addr` |
| sched | input | 1 | Pipeline takes the offered entry |
| commit | input | 1 | The in-flight entry hit on replay; free it |
| deq_valid | output | 1 | A ready entry is offered |
| deq_addr | output | AW | Offered line address |
| deq_wsel | output | WSW | Offered word select |
| deq_wdata | output | WW | Offered write word |
| deq_tid | output | TIDW | Offered thread id |
| deq_tag | output | TAGW | Offered tag |
| deq_wr | output | 1 | Offered write flag |
| deq_ben | output | WW/8 | Offered byte enables |
| deq_snp | output | 1 | Offered snoop flag |
| deq_snp_inv | output | 1 | Offered snoop invalidate flag |
| full | output | 1 | No free slot |
| almost_full | output | 1 | Fewer than GAP free slots |
| empty | output | 1 | No occupied slot |

## Verification
Enqueue, fill, schedule, commit and send-back all act on the clock edge that samples them. Their effect on `deq_valid`, the dequeue fields, `full`, `almost_full` and `empty` is therefore due one cycle later. `hazard` follows `probe_addr` with no register, and it follows slot occupancy with one cycle of delay. The bench drives each strobe for exactly one edge and checks one time unit after that edge. For hazard checks it first changes `probe_addr` and lets it settle, with no clock edge in between. The hazard is swept over every line address of the small configuration, with the expected value computed from the set of occupied lines.

// File: rtl/mpq_pkg.sv
package mpq_pkg;
    // kind of write that the last stage performs into the queue
    typedef enum logic [1:0] {
        WR_NONE  = 2'd0,
        WR_NEW   = 2'd1,
        WR_BACK  = 2'd2
    } wr_kind_e;
endpackage

// File: rtl/mpq_free_pick.sv
module mpq_free_pick #(
    parameter int DEPTH = 8,
    localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic [DEPTH-1:0] occ,
    output logic             any_free,
    output logic [IW-1:0]    free_idx
);
    always_comb begin
        any_free = 1'b0;
        free_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!occ[i]) begin
                any_free = 1'b1;
                free_idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/mpq_line_match.sv
module mpq_line_match #(
    parameter int DEPTH = 8,
    parameter int AW    = 8
) (
    input  logic [DEPTH-1:0][AW-1:0] lines,
    input  logic [AW-1:0]            key,
    output logic [DEPTH-1:0]         eq
);
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign eq[g] = (lines[g] == key);
    end
endmodule

// File: rtl/mpq_age_pick.sv
module mpq_age_pick #(
    parameter int DEPTH = 8,
    localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_en,
    input  logic [IW-1:0]    alloc_idx,
    input  logic [DEPTH-1:0] cand,
    output logic [DEPTH-1:0] pick
);
    // older_q[i][j] = 1 : slot i was allocated before slot j
    logic [DEPTH-1:0][DEPTH-1:0] older_d, older_q;

    always_comb begin
        older_d = older_q;
        if (alloc_en) begin
            for (int j = 0; j < DEPTH; j++) begin
                older_d[alloc_idx][j] = 1'b0;
                if (j != int'(alloc_idx)) older_d[j][alloc_idx] = 1'b1;
            end
        end
        for (int i = 0; i < DEPTH; i++) begin
            logic beaten;
            beaten = 1'b0;
            for (int j = 0; j < DEPTH; j++) begin
                if (j != i && cand[j] && older_q[j][i]) beaten = 1'b1;
            end
            pick[i] = cand[i] && !beaten;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) older_q <= '0;
        else        older_q <= older_d;
    end

    // R6: exactly one oldest candidate is chosen whenever any exists
    a_r6_single_pick: assert property (@(posedge clk) disable iff (!rst_n)
        (|cand) |-> ($onehot0(pick) && (|pick)));
endmodule

// File: rtl/miss_park_queue.sv
module miss_park_queue #(
    parameter int DEPTH = 8,
    parameter int GAP   = 4,
    parameter int AW    = 8,
    parameter int WSW   = 2,
    parameter int WW    = 32,
    parameter int TIDW  = 2,
    parameter int TAGW  = 8,
    localparam int BW   = WW / 8,
    localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int PW   = WSW + WW + TIDW + TAGW + 1 + BW + 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enq_valid,
    input  logic            enq_back,
    input  logic            enq_ready_init,
    input  logic [AW-1:0]   enq_addr,
    input  logic [WSW-1:0]  enq_wsel,
    input  logic [WW-1:0]   enq_wdata,
    input  logic [TIDW-1:0] enq_tid,
    input  logic [TAGW-1:0] enq_tag,
    input  logic            enq_wr,
    input  logic [BW-1:0]   enq_ben,
    input  logic            enq_snp,
    input  logic            enq_snp_inv,
    input  logic            fill_valid,
    input  logic [AW-1:0]   probe_addr,
    output logic            hazard,
    input  logic            sched,
    input  logic            commit,
    output logic            deq_valid,
    output logic [AW-1:0]   deq_addr,
    output logic [WSW-1:0]  deq_wsel,
    output logic [WW-1:0]   deq_wdata,
    output logic [TIDW-1:0] deq_tid,
    output logic [TAGW-1:0] deq_tag,
    output logic            deq_wr,
    output logic [BW-1:0]   deq_ben,
    output logic            deq_snp,
    output logic            deq_snp_inv,
    output logic            full,
    output logic            almost_full,
    output logic            empty
);
    import mpq_pkg::*;

    typedef struct packed {
        logic [DEPTH-1:0]          occ;
        logic [DEPTH-1:0]          rdy;
        logic [DEPTH-1:0]          fly;
        logic                      busy;
        logic [IW-1:0]             fly_idx;
        logic [DEPTH-1:0][AW-1:0]  line;
        logic [DEPTH-1:0][PW-1:0]  pay;
    } state_t;

    state_t st_d, st_q;

    logic [DEPTH-1:0] probe_eq;
    logic [DEPTH-1:0] cand;
    logic [DEPTH-1:0] pick;
    logic             any_free;
    logic [IW-1:0]    free_idx;
    logic [IW-1:0]    pick_idx;
    logic [PW-1:0]    enq_pay;
    logic [PW-1:0]    deq_pay;
    logic             fill_new;
    logic             alloc_en;
    wr_kind_e         kind;
    int               free_cnt;

    mpq_line_match #(.DEPTH(DEPTH), .AW(AW)) u_match (
        .lines (st_q.line),
        .key   (probe_addr),
        .eq    (probe_eq)
    );

    mpq_free_pick #(.DEPTH(DEPTH)) u_free (
        .occ      (st_q.occ),
        .any_free (any_free),
        .free_idx (free_idx)
    );

    mpq_age_pick #(.DEPTH(DEPTH)) u_age (
        .clk       (clk),
        .rst_n     (rst_n),
        .alloc_en  (alloc_en),
        .alloc_idx (free_idx),
        .cand      (cand),
        .pick      (pick)
    );

    always_comb begin
        enq_pay  = {enq_wsel, enq_wdata, enq_tid, enq_tag, enq_wr, enq_ben,
                    enq_snp, enq_snp_inv};
        cand     = st_q.occ & st_q.rdy & ~st_q.fly & {DEPTH{~st_q.busy}};
        pick_idx = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (pick[i]) pick_idx = pick_idx | IW'(i);
        end
        deq_pay   = st_q.pay[pick_idx];
        deq_valid = |cand;
        deq_addr  = st_q.line[pick_idx];
        {deq_wsel, deq_wdata, deq_tid, deq_tag, deq_wr, deq_ben,
         deq_snp, deq_snp_inv} = deq_pay;

        hazard      = |(probe_eq & st_q.occ);
        full        = &st_q.occ;
        empty       = ~|st_q.occ;
        free_cnt    = DEPTH - $countones(st_q.occ);
        almost_full = (free_cnt < GAP);

        fill_new = fill_valid && (enq_addr == probe_addr);
        if (!enq_valid)                       kind = WR_NONE;
        else if (enq_back && st_q.busy)       kind = WR_BACK;
        else if (!enq_back && any_free)       kind = WR_NEW;
        else                                  kind = WR_NONE;
        alloc_en = (kind == WR_NEW);

        st_d = st_q;
        if (fill_valid) begin
            st_d.rdy = st_q.rdy | (probe_eq & st_q.occ & ~st_q.fly);
        end
        if (commit && st_q.busy) begin
            st_d.occ[st_q.fly_idx] = 1'b0;
            st_d.rdy[st_q.fly_idx] = 1'b0;
            st_d.fly[st_q.fly_idx] = 1'b0;
            st_d.busy              = 1'b0;
        end
        if (sched && deq_valid) begin
            st_d.fly[pick_idx] = 1'b1;
            st_d.rdy[pick_idx] = 1'b0;
            st_d.busy          = 1'b1;
            st_d.fly_idx       = pick_idx;
        end
        case (kind)
            WR_BACK: begin
                st_d.fly[st_q.fly_idx]  = 1'b0;
                st_d.rdy[st_q.fly_idx]  = enq_ready_init || fill_new;
                st_d.line[st_q.fly_idx] = enq_addr;
                st_d.pay[st_q.fly_idx]  = enq_pay;
                st_d.busy               = 1'b0;
            end
            WR_NEW: begin
                st_d.occ[free_idx]  = 1'b1;
                st_d.fly[free_idx]  = 1'b0;
                st_d.rdy[free_idx]  = enq_ready_init || fill_new;
                st_d.line[free_idx] = enq_addr;
                st_d.pay[free_idx]  = enq_pay;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R7: once an entry is taken, nothing is offered on the next cycle
    a_r7_hold_after_sched: assert property (@(posedge clk) disable iff (!rst_n)
        (sched && deq_valid && !commit && !enq_valid) |=> !deq_valid);
    // R8: freeing the in-flight slot leaves at least one free slot
    a_r8_commit_frees: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && st_q.busy && !enq_valid) |=> !full);
    // R9: a send-back is only legal while an entry is in flight
    a_r9_back_needs_flight: assert property (@(posedge clk) disable iff (!rst_n)
        (enq_valid && enq_back) |-> st_q.busy);
    // R9: a send-back does not change occupancy
    a_r9_back_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
        (enq_valid && enq_back && !commit) |=> $stable(full) && $stable(empty));
    // R5: a freshly parked line is seen by the hazard check
    a_r5_hazard_new: assert property (@(posedge clk) disable iff (!rst_n)
        (enq_valid && !enq_back && !full) |=>
            (hazard || (probe_addr != $past(enq_addr))));
    // R10: full always implies almost full and never empty
    a_r10_full_flags: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> (almost_full && !empty));
    // R3: an offer needs a parked entry
    a_r3_offer_needs_entry: assert property (@(posedge clk) disable iff (!rst_n)
        deq_valid |-> !empty);
endmodule

// File: tb/miss_park_queue_tb.sv
module miss_park_queue_tb;
    localparam int DEPTH = 4;
    localparam int GAP   = 2;
    localparam int AW    = 4;
    localparam int WSW   = 2;
    localparam int WW    = 16;
    localparam int TIDW  = 2;
    localparam int TAGW  = 4;
    localparam int BW    = WW / 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enq_valid, enq_back, enq_ready_init;
    logic [AW-1:0] enq_addr, probe_addr;
    logic [WSW-1:0] enq_wsel;
    logic [WW-1:0] enq_wdata;
    logic [TIDW-1:0] enq_tid;
    logic [TAGW-1:0] enq_tag;
    logic enq_wr, enq_snp, enq_snp_inv;
    logic [BW-1:0] enq_ben;
    logic fill_valid, sched, commit;
    logic hazard, deq_valid, full, almost_full, empty;
    logic [AW-1:0] deq_addr;
    logic [WSW-1:0] deq_wsel;
    logic [WW-1:0] deq_wdata;
    logic [TIDW-1:0] deq_tid;
    logic [TAGW-1:0] deq_tag;
    logic deq_wr, deq_snp, deq_snp_inv;
    logic [BW-1:0] deq_ben;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    miss_park_queue #(.DEPTH(DEPTH), .GAP(GAP), .AW(AW), .WSW(WSW), .WW(WW),
                      .TIDW(TIDW), .TAGW(TAGW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .enq_valid(enq_valid), .enq_back(enq_back), .enq_ready_init(enq_ready_init),
        .enq_addr(enq_addr), .enq_wsel(enq_wsel), .enq_wdata(enq_wdata),
        .enq_tid(enq_tid), .enq_tag(enq_tag), .enq_wr(enq_wr), .enq_ben(enq_ben),
        .enq_snp(enq_snp), .enq_snp_inv(enq_snp_inv),
        .fill_valid(fill_valid), .probe_addr(probe_addr), .hazard(hazard),
        .sched(sched), .commit(commit),
        .deq_valid(deq_valid), .deq_addr(deq_addr), .deq_wsel(deq_wsel),
        .deq_wdata(deq_wdata), .deq_tid(deq_tid), .deq_tag(deq_tag),
        .deq_wr(deq_wr), .deq_ben(deq_ben), .deq_snp(deq_snp),
        .deq_snp_inv(deq_snp_inv),
        .full(full), .almost_full(almost_full), .empty(empty)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        enq_valid = 0; enq_back = 0; enq_ready_init = 0; enq_addr = '0;
        enq_wsel = '0; enq_wdata = '0; enq_tid = '0; enq_tag = '0; enq_wr = 0;
        enq_ben = '0; enq_snp = 0; enq_snp_inv = 0;
        fill_valid = 0; sched = 0; commit = 0;
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
        idle();
    endtask

    // payload fields are derived arithmetically from address and tag
    function automatic logic [WW-1:0] wd_of(input logic [AW-1:0] a, input logic [TAGW-1:0] t);
        return {t, a, 8'h5A} ^ 16'h0F0F;
    endfunction

    task automatic put(input logic [AW-1:0] a, input logic [TAGW-1:0] t,
                       input logic rinit, input logic back);
        enq_valid = 1; enq_back = back; enq_ready_init = rinit; enq_addr = a;
        enq_wsel = a[1:0] ^ 2'b11; enq_wdata = wd_of(a, t); enq_tid = t[1:0];
        enq_tag = t; enq_wr = t[0]; enq_ben = {t[1], ~t[1]};
        enq_snp = t[1]; enq_snp_inv = t[2];
    endtask

    task automatic probe(input logic [AW-1:0] a);
        probe_addr = a;
        #1;
    endtask

    task automatic pop_commit();
        sched = 1; cyc();
        commit = 1; cyc();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        idle();
        probe_addr = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        cyc();
        // R1 reset state
        check("R1 empty", empty, 1);
        check("R1 full", full, 0);
        check("R1 almost_full", almost_full, 0);
        check("R1 deq_valid", deq_valid, 0);
        check("R1 hazard", hazard, 0);

        // entry A: line 3, waiting
        put(4'd3, 4'd1, 1'b0, 1'b0); cyc();
        check("R3 waiting not offered", deq_valid, 0);
        check("R3 not empty", empty, 0);
        probe(4'd3); check("R5 hazard match", hazard, 1);
        probe(4'd5); check("R5 hazard no match", hazard, 0);

        // entry B: line 5, ready at once
        put(4'd5, 4'd6, 1'b1, 1'b0); cyc();
        check("R3 ready offered", deq_valid, 1);
        check("R2 addr", deq_addr, 5);
        check("R2 tag", deq_tag, 6);
        check("R2 wsel", deq_wsel, 2'd1 ^ 2'b11);
        check("R2 wdata", deq_wdata, wd_of(4'd5, 4'd6));
        check("R2 tid", deq_tid, 2'd2);
        check("R2 wr", deq_wr, 0);
        check("R2 ben", deq_ben, 2'b10);
        check("R2 snp", deq_snp, 1);
        check("R2 snp_inv", deq_snp_inv, 1);
        check("R11 two free", almost_full, 0);

        // fill line 3: A becomes ready and is older than B
        fill_valid = 1; probe_addr = 4'd3; cyc();
        check("R4 fill readies A", deq_addr, 3);
        check("R6 oldest first", deq_tag, 1);

        // entry C: line 3, waiting (fill already consumed)
        put(4'd3, 4'd3, 1'b0, 1'b0); cyc();
        check("R11 one free", almost_full, 1);
        check("R10 not full", full, 0);

        // schedule A
        sched = 1; cyc();
        check("R7 nothing offered while in flight", deq_valid, 0);

        // A misses again and is sent back waiting
        put(4'd3, 4'd1, 1'b0, 1'b1); cyc();
        check("R9 B offered after send-back", deq_addr, 5);
        check("R9 no new slot", full, 0);
        check("R9 occupancy kept", almost_full, 1);

        // entry D fills the queue
        put(4'd7, 4'd4, 1'b0, 1'b0); cyc();
        check("R10 full", full, 1);

        // enqueue while full is dropped
        put(4'd9, 4'd5, 1'b1, 1'b0); cyc();
        probe(4'd9); check("R10 dropped entry absent", hazard, 0);
        check("R10 offer unchanged", deq_addr, 5);

        // fill line 3: A and C ready; A kept its age
        fill_valid = 1; probe_addr = 4'd3; cyc();
        check("R9 age kept", deq_tag, 1);
        check("R4 fill readies several", deq_addr, 3);

        pop_commit();
        check("R8 commit frees slot", full, 0);
        check("R6 next oldest B", deq_addr, 5);
        pop_commit();
        check("R6 then C addr", deq_addr, 3);
        check("R6 then C tag", deq_tag, 3);
        probe(4'd3); check("R5 C still parked", hazard, 1);
        pop_commit();
        check("R3 D still waiting", deq_valid, 0);
        probe(4'd3); check("R8 line 3 freed", hazard, 0);

        // entry F enqueued together with a matching fill
        put(4'd9, 4'd6, 1'b0, 1'b0); fill_valid = 1; probe_addr = 4'd9; cyc();
        check("R4 same-cycle fill", deq_valid, 1);
        check("R4 same-cycle fill addr", deq_addr, 9);

        // hazard sweep over all lines: parked lines are 7 and 9
        for (int a = 0; a < (1 << AW); a++) begin
            probe(AW'(a));
            check("R5 sweep", hazard, ((a == 7) || (a == 9)) ? 1 : 0);
        end

        pop_commit();
        check("R4 other line untouched", deq_valid, 0);
        fill_valid = 1; probe_addr = 4'd7; cyc();
        check("R4 fill line 7", deq_addr, 7);
        pop_commit();
        check("R8 drained empty", empty, 1);
        check("R8 drained offer", deq_valid, 0);
        check("R11 drained", almost_full, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule